// File: doc/BRIEF.md
# Character-Framed Synchronous Serial Transmitter

This block turns parallel characters into a synchronous serial stream for byte-framed links such as Bisync. A one-character holding buffer sits in front of a shift register. Each pulse of the bit-rate enable sends one bit, least significant first. A running CRC-16 is kept over the characters that were loaded while CRC accumulation was enabled. When the buffer runs dry, the block fills the line on its own. It sends the accumulated CRC when one is pending. Otherwise it sends a 16-bit fill pattern made from two programmable 8-bit registers.

Turning the transmitter off, or sending a break, never leaves a partial slot on the line. The only exception is a break, which takes effect at once by design. The block also reports three one-cycle status events: start of a CRC slot, start of a fill slot, and any edge on the clear-to-send input.

Top module: `sync_char_tx`

## Requirements
- R1: After reset `txd` is 1 (mark), `buf_empty` is 1, and `ev_crc`, `ev_sync` and `ev_cts` are 0.
- R2: A pulse on `ld` stores `ld_data` and clears `buf_empty`. At the next `bit_en` taken at a character boundary, the buffer moves into the shifter and `buf_empty` returns to 1. The character leaves LSB first, one bit per `bit_en`. Its length is 5, 6, 7 or 8 bits for `wlen` codes 0, 1, 2 and 3. Bits above that length are ignored.
- R3: On underrun with no CRC pending, or with `crc_en` low, a 16-bit fill slot is sent: `sync_a` LSB first, then `sync_b` LSB first. It repeats until data arrives. Each fill slot start raises `ev_sync` for one cycle.
- R4: With `transp` high, an underrun always sends the `sync_a`/`sync_b` pair (DLE then SYN), even when CRC is pending.
- R5: With `transp` low, an underrun while `crc_en` is high and CRC is pending sends the 16-bit CRC once, LSB first. The slot start raises `ev_crc` for one cycle, and fill slots follow.
- R6: The CRC uses x^16+x^15+x^2+1 in bit-reflected form (0xA001), shifted LSB first. It starts at zero and is cleared whenever a fill slot starts.
- R7: `crc_en` is sampled when a character moves into the shifter. Characters moved in while it is low do not change the CRC.
- R8: If `tx_en` falls during a data or fill slot, that slot completes. The line then holds mark. A character in the buffer is kept and is sent after `tx_en` returns.
- R9: If `tx_en` is low at any point in a CRC slot, the slot still runs 16 bits. From that point on, each bit is taken from the same position of the fill pair instead of the CRC. The line then holds mark.
- R10: While `brk` is high, `txd` is 0 in the same cycle, and `ld` is ignored. The buffer and shifter are emptied. After release the line is at mark until the next slot starts.
- R11: Each rising or falling edge of `cts` produces exactly one single-cycle `ev_cts` pulse, after a two-flop synchroniser.
- R12: `ev_crc` and `ev_sync` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One pulse per transmitted bit |
| tx_en | input | 1 | Transmitter enable |
| crc_en | input | 1 | CRC accumulation for the next character moved in; CRC slot allowed on underrun |
| brk | input | 1 | Force the line to space and flush |
| wlen | input | 2 | Character length code: 0=5, 1=6, 2=7, 3=8 bits |
| transp | input | 1 | Transparent mode: underrun sends the DLE/SYN pair |
| sync_a | input | 8 | First fill character (DLE in transparent mode) |
| sync_b | input | 8 | Second fill character (SYN) |
| ld | input | 1 | Write strobe for the holding buffer |
| ld_data | input | 8 | Character to load |
| cts | input | 1 | Clear-to-send, asynchronous |
| txd | output | 1 | Serial data |
| buf_empty | output | 1 | Holding buffer empty |
| ev_crc | output | 1 | CRC slot started (one cycle) |
| ev_sync | output | 1 | Fill slot started (one cycle) |
| ev_cts | output | 1 | Edge seen on `cts` (one cycle) |

## Verification
A wrong slot counter or slot kind shows up on `txd` as early as the next `bit_en`. Either the character boundary falls in the wrong place, or the fill or CRC begins one bit too early or too late. That is caught by comparing whole slots bit by bit. A corrupted CRC register or a wrong per-character gate stays hidden until the next CRC slot, so the bench ends messages with CRC slots after gated and ungated characters. A lost or stale holding buffer appears on `buf_empty` at once. It also shows as a wrong character after a disable or break, within one slot.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_DATA = 2'd1,
    K_SYNC = 2'd2,
    K_CRC  = 2'd3
  } slot_e;

  // character length in bits for a 2-bit length code: shortest is char_w-3
  function automatic int char_len(input logic [1:0] code, input int char_w);
    return char_w - 3 + int'(code);
  endfunction

endpackage

// File: rtl/stx_rst_sync.sv
module stx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = q[STAGES-1];

endmodule

// File: rtl/stx_edge_det.sv
module stx_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic pulse
);

  logic [STAGES:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-1:0], d};
  end

  assign pulse = sr[STAGES] ^ sr[STAGES-1];

endmodule

// File: rtl/stx_crc16.sv
module stx_crc16 #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'hA001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         upd,
  input  logic         bit_in,
  output logic [W-1:0] crc_q,
  output logic [W-1:0] crc_adv
);

  logic [W-1:0] crc_n;
  logic         fb;

  always_comb begin
    fb      = crc_q[0] ^ bit_in;
    crc_adv = (crc_q >> 1) ^ (fb ? POLY : '0);
    crc_n   = crc_q;
    if (clr)      crc_n = '0;
    else if (upd) crc_n = crc_adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_n;
  end

endmodule

// File: rtl/sync_char_tx.sv
module sync_char_tx #(
  parameter int                CHAR_W     = 8,
  parameter int                CRC_W      = 2 * CHAR_W,
  parameter logic [CRC_W-1:0]  CRC_POLY   = CRC_W'(16'hA001),
  parameter int                RST_STAGES = 2,
  parameter int                CTS_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              tx_en,
  input  logic              crc_en,
  input  logic              brk,
  input  logic [1:0]        wlen,
  input  logic              transp,
  input  logic [CHAR_W-1:0] sync_a,
  input  logic [CHAR_W-1:0] sync_b,
  input  logic              ld,
  input  logic [CHAR_W-1:0] ld_data,
  input  logic              cts,
  output logic              txd,
  output logic              buf_empty,
  output logic              ev_crc,
  output logic              ev_sync,
  output logic              ev_cts
);
  import stx_pkg::*;

  localparam int SLOT_W = 2 * CHAR_W;
  localparam int CNT_W  = $clog2(SLOT_W + 1);
  localparam int IDX_W  = $clog2(SLOT_W);

  logic rst_i;

  logic [CHAR_W-1:0] buf_q, buf_n;
  logic              full_q, full_n;
  slot_e             kind_q, kind_n;
  logic [SLOT_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              chcrc_q, chcrc_n;
  logic              dirty_q, dirty_n;
  logic              swap_q, swap_n;
  logic              evc_q, evs_q;

  logic              at_end, go_crc, go_sync, crc_upd;
  logic [CRC_W-1:0]  crc_q, crc_adv, crc_now;
  logic [SLOT_W-1:0] fill_w;
  logic [IDX_W-1:0]  sidx;

  stx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_i)
  );

  stx_edge_det #(.STAGES(CTS_STAGES)) u_cts (
    .clk(clk), .rst_n(rst_i), .d(cts), .pulse(ev_cts)
  );

  stx_crc16 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_i), .clr(go_sync), .upd(crc_upd),
    .bit_in(sh_q[0]), .crc_q(crc_q), .crc_adv(crc_adv)
  );

  assign fill_w  = {sync_b, sync_a};
  assign at_end  = (kind_q == K_IDLE) || (cnt_q <= CNT_W'(1));
  assign crc_upd = bit_en && !brk && (kind_q == K_DATA) && chcrc_q;
  assign crc_now = crc_upd ? crc_adv : crc_q;
  assign sidx    = IDX_W'(CNT_W'(SLOT_W) - cnt_q);

  // next-state logic
  always_comb begin
    buf_n   = buf_q;
    full_n  = full_q;
    kind_n  = kind_q;
    sh_n    = sh_q;
    cnt_n   = cnt_q;
    chcrc_n = chcrc_q;
    dirty_n = dirty_q;
    swap_n  = swap_q;
    go_crc  = 1'b0;
    go_sync = 1'b0;
    if (brk) begin
      full_n = 1'b0;
      kind_n = K_IDLE;
      cnt_n  = '0;
      swap_n = 1'b0;
    end else begin
      if (ld) begin
        buf_n  = ld_data;
        full_n = 1'b1;
      end
      if (kind_q == K_CRC && !tx_en) swap_n = 1'b1;
      if (bit_en) begin
        if (!at_end) begin
          sh_n  = sh_q >> 1;
          cnt_n = cnt_q - CNT_W'(1);
        end else begin
          swap_n = 1'b0;
          if (!tx_en) begin
            kind_n = K_IDLE;
            cnt_n  = '0;
          end else if (full_q) begin
            kind_n  = K_DATA;
            sh_n    = {{CHAR_W{1'b0}}, buf_q};
            cnt_n   = CNT_W'(char_len(wlen, CHAR_W));
            chcrc_n = crc_en;
            if (crc_en) dirty_n = 1'b1;
            full_n  = ld;
          end else if (!transp && crc_en && dirty_q) begin
            kind_n  = K_CRC;
            sh_n    = crc_now;
            cnt_n   = CNT_W'(SLOT_W);
            dirty_n = 1'b0;
            go_crc  = 1'b1;
          end else begin
            kind_n  = K_SYNC;
            sh_n    = fill_w;
            cnt_n   = CNT_W'(SLOT_W);
            dirty_n = 1'b0;
            go_sync = 1'b1;
          end
        end
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      buf_q   <= '0;
      full_q  <= 1'b0;
      kind_q  <= K_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      chcrc_q <= 1'b0;
      dirty_q <= 1'b0;
      swap_q  <= 1'b0;
      evc_q   <= 1'b0;
      evs_q   <= 1'b0;
    end else begin
      buf_q   <= buf_n;
      full_q  <= full_n;
      kind_q  <= kind_n;
      sh_q    <= sh_n;
      cnt_q   <= cnt_n;
      chcrc_q <= chcrc_n;
      dirty_q <= dirty_n;
      swap_q  <= swap_n;
      evc_q   <= go_crc;
      evs_q   <= go_sync;
    end
  end

  always_comb begin
    if (brk)                           txd = 1'b0;
    else if (kind_q == K_IDLE)         txd = 1'b1;
    else if (kind_q == K_CRC && swap_q) txd = fill_w[sidx];
    else                               txd = sh_q[0];
  end

  assign buf_empty = !full_q;
  assign ev_crc    = evc_q;
  assign ev_sync   = evs_q;

endmodule

// File: rtl/stx_chk.sv
module stx_chk (
  input logic clk,
  input logic rst_n,
  input logic ld,
  input logic brk,
  input logic tx_en,
  input logic transp,
  input logic crc_en,
  input logic buf_empty,
  input logic ev_crc,
  input logic ev_sync
);

  // R10
  brk_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> buf_empty);

  // R2
  fill_by_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_empty) |-> $past(ld));

  // R8
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> ($past(tx_en) || $past(brk)));

  // R5
  crc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_crc |-> ($past(crc_en) && !$past(transp) && $past(buf_empty)));

  // R3
  fill_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |-> $past(buf_empty));

  // R12
  crc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_crc |=> !ev_crc);

  // R12
  sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |=> !ev_sync);

  // R12
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_crc, ev_sync}));

endmodule

bind sync_char_tx stx_chk u_chk (.*);

// File: tb/sim_sync_char_tx.sv
module sim_sync_char_tx;

  logic       clk, rst_n, bit_en, tx_en, crc_en, brk, transp, ld, cts;
  logic [1:0] wlen;
  logic [7:0] sync_a, sync_b, ld_data;
  logic       txd, buf_empty, ev_crc, ev_sync, ev_cts;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sync_char_tx u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_en(tx_en), .crc_en(crc_en),
    .brk(brk), .wlen(wlen), .transp(transp), .sync_a(sync_a), .sync_b(sync_b),
    .ld(ld), .ld_data(ld_data), .cts(cts), .txd(txd), .buf_empty(buf_empty),
    .ev_crc(ev_crc), .ev_sync(ev_sync), .ev_cts(ev_cts)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {data, wlen, transp, crc_en}
  localparam logic [11:0] VEC [6] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0},
    {8'h3C, 2'd3, 1'b0, 1'b1},
    {8'hE6, 2'd0, 1'b0, 1'b1},
    {8'h9B, 2'd1, 1'b1, 1'b1},
    {8'h4D, 2'd2, 1'b0, 1'b1},
    {8'h81, 2'd3, 1'b1, 1'b0}
  };

  function automatic logic [15:0] crc_ref(input logic [7:0] d, input int n);
    logic [15:0] c;
    logic        fb;
    c = 16'h0000;
    for (int i = 0; i < n; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 16'hA001;
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_period(output logic b, output logic ec, output logic es);
    logic c1, s1;
    @(negedge clk);
    b = txd;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    c1 = ev_crc;
    s1 = ev_sync;
    @(negedge clk);
    ec = c1 && !ev_crc;
    es = s1 && !ev_sync;
  endtask

  task automatic grab(input int n, output logic [15:0] v, output logic ec, output logic es);
    logic b;
    v = '0;
    for (int i = 0; i < n; i++) begin
      bit_period(b, ec, es);
      v[i] = b;
    end
  endtask

  task automatic load(input logic [7:0] d);
    @(negedge clk);
    ld_data = d;
    ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    brk = 1'b1;
    @(negedge clk);
    brk = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (R1..R12 run) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, fillw;
    logic ec, es, b;
    logic [7:0] d;
    int w, cnt;

    rst_n = 1'b0; bit_en = 1'b0; tx_en = 1'b1; crc_en = 1'b0; brk = 1'b0;
    transp = 1'b0; ld = 1'b0; cts = 1'b0; wlen = 2'd3; ld_data = '0;
    sync_a = 8'h10; sync_b = 8'h32;
    fillw = {sync_b, sync_a};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 txd", 32'(txd), 32'd1);
    chk("R1 buf_empty", 32'(buf_empty), 32'd1);
    chk("R1 events", 32'({ev_crc, ev_sync, ev_cts}), 32'd0);

    // table of single-character messages (R2 R3 R4 R5 R6)
    for (int k = 0; k < 6; k++) begin
      d = VEC[k][11:4];
      wlen = VEC[k][3:2];
      transp = VEC[k][1];
      crc_en = VEC[k][0];
      w = 5 + int'(wlen);
      flush();
      load(d);
      chk("R2 buf full after load", 32'(buf_empty), 32'd0);
      bit_period(b, ec, es);
      chk("R2 idle mark before start", 32'(b), 32'd1);
      chk("R2 buf empty after transfer", 32'(buf_empty), 32'd1);
      grab(w, v, ec, es);
      chk("R2 data bits LSB first", 32'(v), 32'(d & 8'((1 << w) - 1)));
      if (crc_en && !transp) begin
        chk("R5 ev_crc pulse", 32'(ec), 32'd1);
        grab(16, v, ec, es);
        chk("R6 crc slot", 32'(v), 32'(crc_ref(d, w)));
        chk("R3 ev_sync after crc", 32'(es), 32'd1);
      end else begin
        chk("R3 R4 ev_sync pulse", 32'(es), 32'd1);
        grab(16, v, ec, es);
        chk("R3 R4 fill pair", 32'(v), 32'(fillw));
      end
    end

    // R7 per-character gating
    flush();
    transp = 1'b0; wlen = 2'd3; crc_en = 1'b1;
    load(8'hD2);
    bit_period(b, ec, es);
    crc_en = 1'b0;
    load(8'h6B);
    grab(8, v, ec, es);
    chk("R7 first char", 32'(v), 32'h00D2);
    crc_en = 1'b1;
    grab(8, v, ec, es);
    chk("R7 second char", 32'(v), 32'h006B);
    chk("R5 ev_crc after gated msg", 32'(ec), 32'd1);
    grab(16, v, ec, es);
    chk("R7 crc covers first only", 32'(v), 32'(crc_ref(8'hD2, 8)));
    chk("R12 ev_sync single pulse", 32'(es), 32'd1);
    grab(16, v, ec, es);
    chk("R3 fill repeats after crc", 32'(v), 32'(fillw));
    grab(16, v, ec, es);
    chk("R3 fill repeats again", 32'(v), 32'(fillw));

    // R8 disable during a data character
    flush();
    crc_en = 1'b0;
    load(8'hC3);
    bit_period(b, ec, es);
    load(8'h5A);
    grab(3, v, ec, es);
    tx_en = 1'b0;
    d = 8'(v[2:0]);
    grab(5, v, ec, es);
    chk("R8 char completes", 32'({v[4:0], d[2:0]}), 32'h00C3);
    grab(3, v, ec, es);
    chk("R8 mark after disable", 32'(v), 32'h0007);
    chk("R8 buffer kept", 32'(buf_empty), 32'd0);
    tx_en = 1'b1;
    bit_period(b, ec, es);
    grab(8, v, ec, es);
    chk("R8 kept char sent", 32'(v), 32'h005A);

    // R9 disable during CRC slot
    flush();
    crc_en = 1'b1;
    load(8'h77);
    bit_period(b, ec, es);
    grab(8, v, ec, es);
    grab(4, v, ec, es);
    chk("R9 crc head", 32'(v[3:0]), 32'(crc_ref(8'h77, 8) & 16'h000F));
    tx_en = 1'b0;
    grab(12, v, ec, es);
    chk("R9 fill bits replace crc", 32'(v[11:0]), 32'(fillw[15:4]));
    grab(2, v, ec, es);
    chk("R9 mark after slot", 32'(v), 32'h0003);
    tx_en = 1'b1;

    // R10 break
    flush();
    crc_en = 1'b0;
    load(8'hF0);
    bit_period(b, ec, es);
    load(8'h0F);
    grab(2, v, ec, es);
    @(negedge clk);
    brk = 1'b1;
    #1;
    chk("R10 immediate space", 32'(txd), 32'd0);
    load(8'hAA);
    @(negedge clk);
    brk = 1'b0;
    #1;
    chk("R10 buffer discarded", 32'(buf_empty), 32'd1);
    chk("R10 mark after release", 32'(txd), 32'd1);
    bit_period(b, ec, es);
    chk("R10 ev_sync on restart", 32'(es), 32'd1);
    grab(16, v, ec, es);
    chk("R10 shifter discarded", 32'(v), 32'(fillw));

    // R11 cts edges
    flush();
    @(negedge clk);
    cts = 1'b1;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ev_cts) cnt++;
    end
    chk("R11 rising edge pulse", 32'(cnt), 32'd1);
    cts = 1'b0;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ev_cts) cnt++;
    end
    chk("R11 falling edge pulse", 32'(cnt), 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule